// File: doc/BRIEF.md
# Single-Cycle Address Translation Buffer

This block turns a 32-bit virtual address into a physical address inside the same cycle in which the address is presented. It holds 64 translation entries. The virtual side of each entry is a tag made of a 20-bit virtual page number, a 6-bit address-space identifier and a global flag. These tags sit in a content-addressable array that is searched in parallel. The matching entry's 6-bit index then reads a separate array of physical data: a 20-bit frame number and the uncached, writable and valid attribute bits. The 12-bit page offset is not translated.

The lookup path has no register in it. The pipeline can present an address early in its memory access cycle, for example from the opposite clock edge, and use the result before the next edge, so no pipeline stage is added. A privileged write port loads the tag and physical data of one indexed entry on a rising edge. In kernel mode, the direct-mapped window bypasses the array. Every lookup reports one fault code and no more. Exception vectoring and coprocessor registers belong to the surrounding core.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, all 64 entries have valid clear and an all-zero tag, so a mapped lookup with a nonzero page number gets fault code 1 (refill).
- R2: A mapped lookup whose page number and identifier match an entry with valid and writable set gives hit_o=1, fault_o=0 and paddr_o = {frame, vaddr[11:0]} in the same cycle.
- R3: An entry with the global flag clear matches only an equal identifier. An entry with the global flag set matches any identifier.
- R4: A match on an entry whose valid bit is clear gives fault code 2 (invalid) and hit_o=0.
- R5: A store that matches a valid entry whose writable bit is clear gives fault code 3 (modify) and hit_o=0. A load to the same entry hits.
- R6: A write with wr_en_i=1 changes entry wr_idx_i at the rising edge. A lookup in the write's own cycle sees the old contents, and the next cycle sees the new contents.
- R7: In kernel mode (lk_kernel_i=1), an address with vaddr[31:30]=2'b10 bypasses the array: paddr_o = {3'b000, vaddr[28:0]} with hit_o=1. uncached_o equals vaddr[29]. An address with vaddr[31:30]=2'b11 is translated through the array.
- R8: In user mode, an address with vaddr[31]=1 gives fault code 4 (privilege) and hit_o=0, whatever the array holds.
- R9: When more than one entry matches, the entry with the lowest index supplies the translation.
- R10: On a mapped hit, uncached_o equals the uncached bit of the matching entry.
- R11: With lk_req_i=0, hit_o=0 and fault_o=0. Fault priority is privilege, then refill, then invalid, then modify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_req_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual address |
| lk_asid_i | input | 6 | Current address-space identifier |
| lk_kernel_i | input | 1 | Kernel mode |
| lk_store_i | input | 1 | Access is a store |
| wr_en_i | input | 1 | Load one entry |
| wr_idx_i | input | 6 | Entry index to load |
| wr_vpn_i | input | 20 | Virtual page number of the new tag |
| wr_asid_i | input | 6 | Identifier of the new tag |
| wr_global_i | input | 1 | Global flag of the new tag |
| wr_pfn_i | input | 20 | Physical frame number |
| wr_nc_i | input | 1 | Uncached attribute |
| wr_dirty_i | input | 1 | Writable attribute |
| wr_valid_i | input | 1 | Valid attribute |
| paddr_o | output | 32 | Physical address, meaningful when hit_o=1 |
| hit_o | output | 1 | Translation delivered without fault |
| uncached_o | output | 1 | Access bypasses the cache |
| fault_o | output | 3 | 0 none, 1 refill, 2 invalid, 3 modify, 4 privilege |

## Verification
The bench loads two entries that share a page number, so a reversed priority encoder returns the wrong frame. It then overwrites the lower entry and checks that the higher one takes over. A lookup issued in the same cycle as a write targets the page being written, so a write path that bypasses into the lookup would hit one cycle early. Global and non-global entries are probed with foreign identifiers, and stores are driven to non-writable pages. A design that ignored the identifier, or that checked the writable bit on loads, would report hits or faults that the reference model does not expect. Kernel and user accesses across all address quadrants catch a wrong segment decode, such as translating the direct window, missing the uncached half, or letting user code reach kernel space.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_REFILL = 3'd1,
    FLT_INVAL  = 3'd2,
    FLT_MOD    = 3'd3,
    FLT_PRIV   = 3'd4
  } fault_e;

  localparam int unsigned VA_W = 32;
  // kernel direct window: top two bits 2'b10, bit 29 selects uncached half
  localparam logic [1:0] DIRECT_SEG = 2'b10;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [VPN_W-1:0]   wr_vpn_i,
  input  logic [ASID_W-1:0]  wr_asid_i,
  input  logic               wr_global_i,
  input  logic [VPN_W-1:0]   look_vpn_i,
  input  logic [ASID_W-1:0]  look_asid_i,
  output logic [ENTRIES-1:0] match_o
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic              glob_q;
    logic              sel;

    assign sel = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vpn_q  <= '0;
        asid_q <= '0;
        glob_q <= 1'b0;
      end else if (sel) begin
        vpn_q  <= wr_vpn_i;
        asid_q <= wr_asid_i;
        glob_q <= wr_global_i;
      end
    end

    assign match_o[i] = (vpn_q == look_vpn_i) && (glob_q || (asid_q == look_asid_i));
  end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int N      = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/tlb_phys_ram.sv
module tlb_phys_ram #(
  parameter int ENTRIES = 64,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int DW     = PFN_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PFN_W-1:0] wr_pfn_i,
  input  logic             wr_nc_i,
  input  logic             wr_dirty_i,
  input  logic             wr_valid_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PFN_W-1:0] rd_pfn_o,
  output logic             rd_nc_o,
  output logic             rd_dirty_o,
  output logic             rd_valid_o
);
  logic [DW-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= {wr_pfn_i, wr_nc_i, wr_dirty_i, wr_valid_i};
    end
  end

  assign {rd_pfn_o, rd_nc_o, rd_dirty_o, rd_valid_o} = mem_q[rd_idx_i];
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 6,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int OFF_W  = VA_W - VPN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_req_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              lk_kernel_i,
  input  logic              lk_store_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_global_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic              wr_nc_i,
  input  logic              wr_dirty_i,
  input  logic              wr_valid_i,
  output logic [VA_W-1:0]   paddr_o,
  output logic              hit_o,
  output logic              uncached_o,
  output logic [2:0]        fault_o
);
  logic [ENTRIES-1:0] match;
  logic               any_match;
  logic [IDX_W-1:0]   hit_idx;
  logic [PFN_W-1:0]   pfn;
  logic               e_nc, e_dirty, e_valid;
  logic               seg_direct, seg_kern;
  fault_e             flt;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_vpn_i, .wr_asid_i, .wr_global_i,
    .look_vpn_i (lk_vaddr_i[VA_W-1:OFF_W]),
    .look_asid_i(lk_asid_i),
    .match_o    (match)
  );

  tlb_prio_enc #(.N(ENTRIES)) u_enc (
    .req_i(match), .any_o(any_match), .idx_o(hit_idx)
  );

  tlb_phys_ram #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_ram (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_pfn_i, .wr_nc_i, .wr_dirty_i, .wr_valid_i,
    .rd_idx_i  (hit_idx),
    .rd_pfn_o  (pfn),
    .rd_nc_o   (e_nc),
    .rd_dirty_o(e_dirty),
    .rd_valid_o(e_valid)
  );

  assign seg_kern   = lk_vaddr_i[VA_W-1];
  assign seg_direct = lk_kernel_i && (lk_vaddr_i[VA_W-1 -: 2] == DIRECT_SEG);

  always_comb begin
    if (!lk_req_i)                       flt = FLT_NONE;
    else if (!lk_kernel_i && seg_kern)   flt = FLT_PRIV;
    else if (seg_direct)                 flt = FLT_NONE;
    else if (!any_match)                 flt = FLT_REFILL;
    else if (!e_valid)                   flt = FLT_INVAL;
    else if (lk_store_i && !e_dirty)     flt = FLT_MOD;
    else                                 flt = FLT_NONE;
  end

  always_comb begin
    if (seg_direct) begin
      paddr_o    = {3'b000, lk_vaddr_i[VA_W-4:0]};
      uncached_o = lk_req_i && lk_vaddr_i[VA_W-3];
    end else begin
      paddr_o    = {pfn, lk_vaddr_i[OFF_W-1:0]};
      uncached_o = lk_req_i && (flt == FLT_NONE) && e_nc;
    end
  end

  assign hit_o   = lk_req_i && (flt == FLT_NONE);
  assign fault_o = flt;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int OFF_W = 12
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        lk_req_i,
  input logic [31:0] lk_vaddr_i,
  input logic        lk_kernel_i,
  input logic [31:0] paddr_o,
  input logic        hit_o,
  input logic        uncached_o,
  input logic [2:0]  fault_o
);
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |-> (!hit_o && fault_o == 3'd0));

  // R8
  user_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_req_i && !lk_kernel_i && lk_vaddr_i[31]) |-> (fault_o == 3'd4 && !hit_o));

  // R7
  direct_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_req_i && lk_kernel_i && lk_vaddr_i[31:30] == 2'b10) |->
      (hit_o && paddr_o == {3'b000, lk_vaddr_i[28:0]} && uncached_o == lk_vaddr_i[29]));

  // R2
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (paddr_o[OFF_W-1:0] == lk_vaddr_i[OFF_W-1:0]));

  // R11
  hit_fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |-> (hit_o == (fault_o == 3'd0)));

  // R10
  nc_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncached_o |-> hit_o);
endmodule

bind tlb_xlate tlb_xlate_chk #(.OFF_W(OFF_W)) chk_i (
  .clk_i, .rst_ni, .lk_req_i, .lk_vaddr_i, .lk_kernel_i,
  .paddr_o, .hit_o, .uncached_o, .fault_o
);

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_req_i = 1'b0;
  logic [31:0] lk_vaddr_i = '0;
  logic [5:0]  lk_asid_i = '0;
  logic        lk_kernel_i = 1'b0;
  logic        lk_store_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_idx_i = '0;
  logic [19:0] wr_vpn_i = '0;
  logic [5:0]  wr_asid_i = '0;
  logic        wr_global_i = 1'b0;
  logic [19:0] wr_pfn_i = '0;
  logic        wr_nc_i = 1'b0, wr_dirty_i = 1'b0, wr_valid_i = 1'b0;
  logic [31:0] paddr_o;
  logic        hit_o, uncached_o;
  logic [2:0]  fault_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference entry state
  logic [19:0] m_vpn [N];
  logic [5:0]  m_asid[N];
  logic        m_g[N], m_nc[N], m_d[N], m_v[N];
  logic [19:0] m_pfn [N];

  tlb_xlate dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic model(output logic [31:0] pa, output logic hit, output logic nc,
                       output logic [2:0] flt);
    int k = -1;
    pa = '0; nc = 0; flt = 0;
    if (!lk_req_i) flt = 0;
    else if (!lk_kernel_i && lk_vaddr_i[31]) flt = 4;
    else if (lk_kernel_i && lk_vaddr_i[31:30] == 2'b10) begin
      pa = {3'b000, lk_vaddr_i[28:0]};
      nc = lk_vaddr_i[29];
    end else begin
      for (int i = 0; i < N; i++)
        if (k < 0 && m_vpn[i] == lk_vaddr_i[31:12] && (m_g[i] || m_asid[i] == lk_asid_i)) k = i;
      if (k < 0) flt = 1;
      else if (!m_v[k]) flt = 2;
      else if (lk_store_i && !m_d[k]) flt = 3;
      else begin
        pa = {m_pfn[k], lk_vaddr_i[11:0]};
        nc = m_nc[k];
      end
    end
    hit = lk_req_i && flt == 0;
  endtask

  // inputs already driven at negedge; compare just before posedge, then update model
  task automatic step(input string req);
    logic [31:0] pa; logic hit, nc; logic [2:0] flt;
    #(CLK_PERIOD/2 - 1);
    model(pa, hit, nc, flt);
    checks++;
    if (hit_o !== hit || fault_o !== flt || uncached_o !== nc || (hit && paddr_o !== pa)) begin
      fails++;
      $display("FAIL %s: got hit=%0b flt=%0d nc=%0b pa=%h, expected hit=%0b flt=%0d nc=%0b pa=%h",
               req, hit_o, fault_o, uncached_o, paddr_o, hit, flt, nc, pa);
    end
    @(posedge clk_i);
    if (wr_en_i) begin
      m_vpn[wr_idx_i] = wr_vpn_i; m_asid[wr_idx_i] = wr_asid_i; m_g[wr_idx_i] = wr_global_i;
      m_pfn[wr_idx_i] = wr_pfn_i; m_nc[wr_idx_i] = wr_nc_i;
      m_d[wr_idx_i] = wr_dirty_i; m_v[wr_idx_i] = wr_valid_i;
    end
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [5:0] asid, input logic kern,
                      input logic st, input string req);
    lk_req_i = 1; lk_vaddr_i = va; lk_asid_i = asid; lk_kernel_i = kern; lk_store_i = st;
    step(req);
  endtask

  task automatic load_ent(input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                          input logic g, input logic [19:0] pfn, input logic nc,
                          input logic d, input logic v);
    wr_en_i = 1; wr_idx_i = 6'(idx); wr_vpn_i = vpn; wr_asid_i = asid; wr_global_i = g;
    wr_pfn_i = pfn; wr_nc_i = nc; wr_dirty_i = d; wr_valid_i = v;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = '0; m_asid[i] = '0; m_g[i] = 0; m_pfn[i] = '0;
      m_nc[i] = 0; m_d[i] = 0; m_v[i] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    look(32'h0040_0123, 6'd5, 0, 0, "R1");
    look(32'hC000_1000, 6'd5, 1, 0, "R1");
    look(32'h0000_0010, 6'd0, 0, 0, "R1 zero tag invalid");
    // R6 same-cycle write sees old, then R2 hit
    load_ent(3, 20'h00400, 6'd5, 0, 20'h12345, 0, 1, 1);
    look(32'h0040_0ABC, 6'd5, 0, 0, "R6 old contents");
    look(32'h0040_0ABC, 6'd5, 0, 0, "R2 R6 new contents");
    look(32'h0040_0ABC, 6'd5, 0, 1, "R2 store");
    // R3
    look(32'h0040_0ABC, 6'd7, 0, 0, "R3 asid mismatch");
    load_ent(10, 20'h00500, 6'd2, 1, 20'h0ABCD, 1, 1, 1);
    look(32'h0050_0004, 6'd9, 0, 0, "R6");
    look(32'h0050_0004, 6'd9, 0, 0, "R3 R10 global");
    // R4
    load_ent(20, 20'h00600, 6'd5, 0, 20'h66666, 0, 1, 0);
    look(32'h0060_0000, 6'd5, 0, 0, "R6");
    look(32'h0060_0FFF, 6'd5, 0, 0, "R4 invalid");
    // R5
    load_ent(21, 20'h00700, 6'd5, 0, 20'h77777, 0, 0, 1);
    look(32'h0070_0000, 6'd5, 0, 0, "R6");
    look(32'h0070_0010, 6'd5, 0, 0, "R5 load hits");
    look(32'h0070_0010, 6'd5, 0, 1, "R5 store modify");
    // R9
    load_ent(40, 20'h00800, 6'd5, 0, 20'h40000, 0, 1, 1);
    look(32'h0080_0000, 6'd5, 0, 0, "R6");
    load_ent(30, 20'h00800, 6'd5, 0, 20'h30000, 0, 1, 1);
    look(32'h0080_0000, 6'd5, 0, 0, "R6");
    look(32'h0080_0123, 6'd5, 0, 0, "R9 lowest index");
    load_ent(30, 20'h00900, 6'd5, 0, 20'h30000, 0, 1, 1);
    look(32'h0080_0123, 6'd5, 0, 0, "R9 R6 before overwrite");
    look(32'h0080_0123, 6'd5, 0, 0, "R9 after overwrite");
    // R7
    look(32'h8012_3456, 6'd5, 1, 0, "R7 cached window");
    look(32'hA012_3456, 6'd5, 1, 1, "R7 uncached window");
    load_ent(50, 20'hC0001, 6'd5, 0, 20'h0C0C0, 0, 1, 1);
    look(32'hC000_1008, 6'd5, 1, 0, "R6");
    look(32'hC000_1008, 6'd5, 1, 0, "R7 mapped kernel quadrant");
    // R8
    look(32'h8000_1000, 6'd5, 0, 0, "R8 user kernel space");
    look(32'hC000_1008, 6'd5, 0, 0, "R8 user mapped kernel");
    // R11
    lk_req_i = 0; lk_vaddr_i = 32'h8000_1000; lk_kernel_i = 0;
    step("R11 idle");
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [3:0] hi;
      if ($urandom_range(0, 2) == 0)
        load_ent($urandom_range(0, 63), {16'h0100, 4'($urandom_range(0, 7))},
                 6'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 20'($urandom),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
      case ($urandom_range(0, 3))
        0: hi = 4'h8; 1: hi = 4'hA; 2: hi = 4'hC; default: hi = 4'h0;
      endcase
      lk_req_i = ($urandom_range(0, 7) != 0);
      lk_vaddr_i = {hi, 8'h01, 4'($urandom_range(0, 7)), 16'($urandom)};
      if (hi == 4'hC) lk_vaddr_i[27:20] = 8'h00;
      if (hi == 4'h0) lk_vaddr_i[27:20] = 8'h10;
      lk_asid_i = 6'($urandom_range(0, 3));
      lk_kernel_i = 1'($urandom_range(0, 1));
      lk_store_i = 1'($urandom_range(0, 1));
      step("R2 R3 R4 R5 R9 mixed");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule